// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches recent virtual-to-physical page translations for a demand-paged memory system. A request presents a 32-bit virtual address and the access length. In the same cycle the block reports a hit together with the physical address, or a request to fill the missing translation. Pages are 512 bytes. Address bits 31:30 choose the region: 00 and 01 are the two process regions and 10 is the system region. The region is kept as part of each stored tag, so system and process translations share one pool of eight slots.

While the tags are compared, the page index is checked against the length limit of its region, so a request that is out of range is flagged in the same cycle as the lookup. The block also flags any access whose bytes spill over into the following page. The page-table walker sits outside the block. After a miss it writes the translation through the fill port, and the block places it in a free slot or in the least recently used slot. Two flush inputs drop either the process translations or all translations.

Top module: `tc_xlate`

## Requirements
- R1: The cache holds eight translations. A fill goes into the lowest-numbered invalid slot while one exists, so eight distinct fills after reset are all retained and all hit afterwards.
- R2: When a valid entry's tag (address bits 31:9) equals the request's bits 31:9 and there is no length fault, `hit` is 1 in the same cycle as `req_valid`. In that cycle `pa` equals the stored frame number concatenated with address bits 8:0.
- R3: When all slots are valid, a fill replaces the entry whose last hit or fill is the oldest. The block keeps exact LRU order.
- R4: Entries from all regions share the pool. The same bits 29:9 stored under two different regions are two separate translations.
- R5: `len_fault` depends on the page index (bits 29:9) and the region. Region 00 faults when the index is at or above `lim_p0`. Region 01 faults when the index is below `lim_p1`, because that region grows downward. Region 10 faults when the index is at or above `lim_sys`. Region 11 always faults.
- R6: `flush_all` invalidates every entry. `flush_proc` invalidates entries of regions 00 and 01 and keeps region 10 entries valid.
- R7: `cross_page` is 1 when `req_valid` is 1 and bits 8:0 plus `req_len_m1` (the length in bytes minus one) exceed 511.
- R8: A length fault takes priority over a miss. While `len_fault` is 1, both `hit` and `fill_req` are 0. Otherwise, with `req_valid` set, exactly one of `hit` and `fill_req` is 1.
- R9: After reset no entry is valid, and every in-range lookup raises `fill_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_va | input | 32 | Virtual address of the request |
| req_len_m1 | input | ALEN_W (3) | Access length in bytes minus one |
| lim_p0 | input | 21 | Page limit of region 00 |
| lim_p1 | input | 21 | Lower page bound of region 01 |
| lim_sys | input | 21 | Page limit of region 10 |
| fill_valid | input | 1 | Write a translation |
| fill_tag | input | 23 | Region and page number (address bits 31:9) to store |
| fill_pfn | input | PFN_W (21) | Physical frame number to store |
| flush_proc | input | 1 | Invalidate process-region entries |
| flush_all | input | 1 | Invalidate all entries |
| hit | output | 1 | Translation found |
| fill_req | output | 1 | Miss with no length fault; translation wanted |
| len_fault | output | 1 | Address beyond its region's limit |
| cross_page | output | 1 | Access spans two pages |
| pa | output | PFN_W+9 (30) | Physical address on hit |

## Verification
The bench builds the block with its default parameters: eight slots and 21-bit frame numbers. The region limits are driven small (16, 4 and 20 pages) so that every region's boundary lies inside a narrow sweep of page indices. A pool of 72 candidate tags is much larger than the eight slots. A long pseudo-random stream of lookups, with a fill after each miss, therefore keeps forcing evictions, and each one is checked against a timestamp-based LRU model. An exhaustive sweep of the last page offsets against every access length covers the page-crossing rule.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 9;
  localparam int TAG_W  = VA_W - OFF_W;
  localparam int RIDX_W = TAG_W - 2;

  typedef enum logic [1:0] {
    RG_P0  = 2'b00,
    RG_P1  = 2'b01,
    RG_SYS = 2'b10,
    RG_BAD = 2'b11
  } region_e;
endpackage

// File: rtl/tc_tag_array.sv
module tc_tag_array
  import tc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PFN_W   = 21,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TAG_W-1:0]   lk_tag,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [PFN_W-1:0]   wr_pfn,
  input  logic               flush_proc,
  input  logic               flush_all,
  output logic [ENTRIES-1:0] match_vec,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [PFN_W-1:0]   match_pfn
);
  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [PFN_W-1:0] pfn_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] sys_vec;

  // storage without reset so it can map onto distributed memory
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      pfn_q[wr_idx] <= wr_pfn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      if (wr_en) valid_q[wr_idx] <= 1'b1;
      if (flush_all) begin
        valid_q <= '0;
      end else if (flush_proc) begin
        for (int i = 0; i < ENTRIES; i++)
          if (!sys_vec[i]) valid_q[i] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_q[g] && (tag_q[g] == lk_tag);
    assign sys_vec[g]   = (region_e'(tag_q[g][TAG_W-1 -: 2]) == RG_SYS);
  end

  always_comb begin
    match_pfn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match_vec[i]) match_pfn = match_pfn | pfn_q[i];
  end

  assign valid_vec = valid_q;

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec)); // R2
  AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> (valid_q == '0)); // R6
  AST_FLUSH_PROC_KEEPS_SYS: assert property (@(posedge clk) disable iff (rst)
    (flush_proc && !flush_all && !wr_en) |=> (valid_q == $past(valid_q & sys_vec))); // R6
endmodule

// File: rtl/tc_lru.sv
module tc_lru #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [IDX_W-1:0]   victim_idx
);
  logic [IDX_W-1:0] rank_q [ENTRIES];
  logic [IDX_W-1:0] free_idx, old_idx;
  logic             have_free;
  logic [(1<<IDX_W)-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)
          rank_q[i] <= '0;
        else if (rank_q[i] < rank_q[touch_idx])
          rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    free_idx  = '0;
    have_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx  = IDX_W'(i);
        have_free = 1'b1;
      end
    end
    old_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (rank_q[i] == IDX_W'(ENTRIES - 1)) old_idx = IDX_W'(i);
    victim_idx = have_free ? free_idx : old_idx;
  end

  always_comb begin
    seen = '0;
    for (int i = 0; i < ENTRIES; i++) seen[rank_q[i]] = 1'b1;
  end

  AST_RANKS_DISTINCT: assert property (@(posedge clk) disable iff (rst)
    seen == '1); // R3
  AST_TOUCH_TO_MRU: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> (rank_q[$past(touch_idx)] == '0)); // R3
endmodule

// File: rtl/tc_limit_check.sv
module tc_limit_check
  import tc_pkg::*;
#(
  parameter int ALEN_W = 3
) (
  input  logic [VA_W-1:0]   va,
  input  logic [ALEN_W-1:0] len_m1,
  input  logic [RIDX_W-1:0] lim_p0,
  input  logic [RIDX_W-1:0] lim_p1,
  input  logic [RIDX_W-1:0] lim_sys,
  output logic              over_limit,
  output logic              spans
);
  region_e           rg;
  logic [RIDX_W-1:0] ridx;
  logic [OFF_W:0]    end_off;

  assign rg   = region_e'(va[VA_W-1 -: 2]);
  assign ridx = va[VA_W-3:OFF_W];

  always_comb begin
    unique case (rg)
      RG_P0:   over_limit = (ridx >= lim_p0);
      RG_P1:   over_limit = (ridx <  lim_p1);
      RG_SYS:  over_limit = (ridx >= lim_sys);
      default: over_limit = 1'b1;
    endcase
  end

  assign end_off = {1'b0, va[OFF_W-1:0]} + (OFF_W+1)'(len_m1);
  assign spans   = end_off[OFF_W];
endmodule

// File: rtl/tc_xlate.sv
module tc_xlate
  import tc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PFN_W   = 21,
  parameter int ALEN_W  = 3,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  input  logic [ALEN_W-1:0] req_len_m1,
  input  logic [RIDX_W-1:0] lim_p0,
  input  logic [RIDX_W-1:0] lim_p1,
  input  logic [RIDX_W-1:0] lim_sys,
  input  logic              fill_valid,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              flush_proc,
  input  logic              flush_all,
  output logic              hit,
  output logic              fill_req,
  output logic              len_fault,
  output logic              cross_page,
  output logic [PA_W-1:0]   pa
);
  logic [ENTRIES-1:0] match_vec, valid_vec;
  logic [PFN_W-1:0]   match_pfn;
  logic [IDX_W-1:0]   victim_idx, hit_idx, touch_idx;
  logic               over_limit, spans, any_match, touch_en;

  tc_tag_array #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_tags (
    .clk(clk), .rst(rst), .lk_tag(req_va[VA_W-1:OFF_W]),
    .wr_en(fill_valid), .wr_idx(victim_idx), .wr_tag(fill_tag), .wr_pfn(fill_pfn),
    .flush_proc(flush_proc), .flush_all(flush_all),
    .match_vec(match_vec), .valid_vec(valid_vec), .match_pfn(match_pfn)
  );

  tc_limit_check #(.ALEN_W(ALEN_W)) u_limit (
    .va(req_va), .len_m1(req_len_m1), .lim_p0(lim_p0), .lim_p1(lim_p1),
    .lim_sys(lim_sys), .over_limit(over_limit), .spans(spans)
  );

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match_vec[i]) hit_idx = IDX_W'(i);
  end

  assign any_match  = |match_vec;
  assign len_fault  = req_valid && over_limit;
  assign hit        = req_valid && !over_limit && any_match;
  assign fill_req   = req_valid && !over_limit && !any_match;
  assign cross_page = req_valid && spans;
  assign pa         = {match_pfn, req_va[OFF_W-1:0]};

  // a fill in the same cycle as a hit owns the LRU update
  assign touch_en  = fill_valid || hit;
  assign touch_idx = fill_valid ? victim_idx : hit_idx;

  tc_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst(rst), .touch_en(touch_en), .touch_idx(touch_idx),
    .valid_vec(valid_vec), .victim_idx(victim_idx)
  );

  AST_FAULT_BLOCKS_ALL: assert property (@(posedge clk) disable iff (rst)
    len_fault |-> (!hit && !fill_req)); // R8
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !len_fault) |-> (hit != fill_req)); // R8
  AST_HIT_HAS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    hit |-> (valid_vec != '0)); // R2
endmodule

// File: tb/tc_xlate_test.sv
`timescale 1ns/1ps
module tc_xlate_test;
  localparam int ENTRIES = 8;
  localparam int PFN_W   = 21;

  logic clk = 1'b0;
  logic rst;
  logic req_valid;
  logic [31:0] req_va;
  logic [2:0]  req_len_m1;
  logic [20:0] lim_p0, lim_p1, lim_sys;
  logic fill_valid;
  logic [22:0] fill_tag;
  logic [PFN_W-1:0] fill_pfn;
  logic flush_proc, flush_all;
  logic hit, fill_req, len_fault, cross_page;
  logic [PFN_W+8:0] pa;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tc_xlate #(.ENTRIES(ENTRIES), .PFN_W(PFN_W), .ALEN_W(3)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
    .req_len_m1(req_len_m1), .lim_p0(lim_p0), .lim_p1(lim_p1), .lim_sys(lim_sys),
    .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_pfn(fill_pfn),
    .flush_proc(flush_proc), .flush_all(flush_all),
    .hit(hit), .fill_req(fill_req), .len_fault(len_fault),
    .cross_page(cross_page), .pa(pa)
  );

  // reference model: last-use timestamps instead of ranks
  bit          m_valid [ENTRIES];
  logic [22:0] m_tag   [ENTRIES];
  logic [PFN_W-1:0] m_pfn [ENTRIES];
  longint      m_ts    [ENTRIES];
  longint      now_ts = 0;

  task automatic chk(input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic bit exp_fault(input logic [31:0] va);
    logic [20:0] ri;
    ri = va[29:9];
    case (va[31:30])
      2'b00:   return ri >= lim_p0;
      2'b01:   return ri <  lim_p1;
      2'b10:   return ri >= lim_sys;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int find(input logic [22:0] t);
    for (int i = 0; i < ENTRIES; i++)
      if (m_valid[i] && m_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic logic [PFN_W-1:0] pfn_of(input logic [22:0] t);
    return PFN_W'((t * 37 + 5) ^ (t >> 3));
  endfunction

  task automatic do_lookup(input logic [31:0] va, input int lm1, output bit need_fill);
    bit f, eh, ef, ec;
    int k;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_len_m1 = lm1[2:0];
    #2;
    f  = exp_fault(va);
    k  = find(va[31:9]);
    eh = !f && (k >= 0);
    ef = !f && (k < 0);
    ec = (int'(va[8:0]) + lm1) > 511;
    chk("R5 len_fault", len_fault, f);
    chk("hit (R1 R3 R4 R6 R9)", hit, eh);
    chk("R8 fill_req", fill_req, ef);
    chk("R7 cross_page", cross_page, ec);
    if (eh) chk("R2 pa", pa, {m_pfn[k], va[8:0]});
    @(posedge clk);
    if (eh) begin now_ts++; m_ts[k] = now_ts; end
    #1 req_valid = 1'b0;
    need_fill = ef;
  endtask

  task automatic do_fill(input logic [22:0] t);
    int v;
    @(negedge clk);
    fill_valid = 1'b1; fill_tag = t; fill_pfn = pfn_of(t);
    @(posedge clk);
    v = -1;
    for (int i = ENTRIES - 1; i >= 0; i--) if (!m_valid[i]) v = i;
    if (v < 0) begin
      v = 0;
      for (int i = 1; i < ENTRIES; i++) if (m_ts[i] < m_ts[v]) v = i;
    end
    now_ts++;
    m_valid[v] = 1; m_tag[v] = t; m_pfn[v] = pfn_of(t); m_ts[v] = now_ts;
    #1 fill_valid = 1'b0;
  endtask

  task automatic do_flush(input bit all);
    @(negedge clk);
    if (all) flush_all = 1'b1; else flush_proc = 1'b1;
    @(posedge clk);
    for (int i = 0; i < ENTRIES; i++)
      if (all || m_tag[i][22:21] != 2'b10) m_valid[i] = 0;
    #1 begin flush_all = 1'b0; flush_proc = 1'b0; end
  endtask

  function automatic logic [22:0] mk(input int rg, input int ri);
    return {rg[1:0], ri[20:0]};
  endfunction

  logic [22:0] tags [9];

  initial begin
    bit nf;
    int lcg;
    rst = 1'b1; req_valid = 0; req_va = '0; req_len_m1 = '0;
    fill_valid = 0; fill_tag = '0; fill_pfn = '0; flush_proc = 0; flush_all = 0;
    lim_p0 = 21'd16; lim_p1 = 21'd4; lim_sys = 21'd20;
    for (int i = 0; i < ENTRIES; i++) begin m_valid[i] = 0; m_ts[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R9 hit idle after reset", hit, 0);
    chk("R9 fill_req idle after reset", fill_req, 0);
    do_lookup({2'b00, 21'd1, 9'h10}, 0, nf);
    chk("R9 miss after reset", nf, 1);

    // R1 R4: eight fills mixing regions, same index in two regions
    tags[0] = mk(0,0); tags[1] = mk(0,1); tags[2] = mk(0,2); tags[3] = mk(1,5);
    tags[4] = mk(1,6); tags[5] = mk(2,0); tags[6] = mk(2,1); tags[7] = mk(2,2);
    tags[8] = mk(0,3);
    for (int i = 0; i < 8; i++) do_fill(tags[i]);
    for (int i = 0; i < 8; i++) begin
      do_lookup({tags[i], 9'h1A0}, 3, nf);
      chk("R1 all eight retained", nf, 0);
    end
    // R3: refresh all but tags[0], then a ninth fill must evict tags[0]
    for (int i = 1; i < 8; i++) do_lookup({tags[i], 9'h004}, 0, nf);
    do_fill(tags[8]);
    do_lookup({tags[0], 9'h000}, 0, nf);
    chk("R3 LRU entry evicted", nf, 1);
    do_lookup({tags[1], 9'h000}, 0, nf);
    chk("R3 recent entry kept", nf, 0);

    // R5: boundary sweep of every region
    for (int rg = 0; rg < 4; rg++)
      for (int ri = 0; ri < 24; ri++)
        do_lookup({rg[1:0], ri[20:0], 9'h055}, 1, nf);
    do_lookup({2'b00, 21'h1FFFFF, 9'h0}, 0, nf);
    do_lookup({2'b10, 21'h1FFFFF, 9'h0}, 0, nf);

    // R7: exhaustive tail offsets against every length
    for (int off = 500; off < 512; off++)
      for (int l = 0; l < 8; l++)
        do_lookup({2'b10, 21'd1, off[8:0]}, l, nf);

    // R6: process flush keeps system entries, full flush clears all
    do_flush(0);
    for (int i = 0; i < 9; i++) do_lookup({tags[i], 9'h0}, 0, nf);
    for (int i = 0; i < 5; i++) do_fill(tags[i]);
    do_flush(1);
    for (int i = 0; i < 9; i++) begin
      do_lookup({tags[i], 9'h0}, 0, nf);
      chk("R6 empty after full flush", nf, 1);
    end

    // pseudo-random traffic with walker stub
    lcg = 12345;
    for (int it = 0; it < 1500; it++) begin
      int rg, ri;
      lcg = (lcg * 1103515245 + 12345) & 32'h7FFFFFFF;
      rg = (lcg >> 8) % 3;
      ri = (lcg >> 12) % 24;
      do_lookup({rg[1:0], ri[20:0], lcg[8:0]}, (lcg >> 20) & 7, nf);
      if (nf) do_fill(mk(rg, ri));
      if (it % 211 == 210) do_flush(0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule